// File: doc/BRIEF.md
# Sensor Command/Response Packet Engine

This block talks to an attached motion sensor through a byte-wide UART core. It builds register-access command packets and hands them over one byte at a time on a ready/valid transmit stream. It then listens on a valid-only receive stream for the sensor's reply. A reply is located by its header byte, never by counting bytes alone. The block decodes the status code in an acknowledge, resends the same command when the reply is bad or missing, and gives up with a sticky error after a bounded number of retries.

A single `start` pulse runs a fixed bring-up sequence of four register writes. When that sequence is finished, `cfg_done` is raised and the block moves to its read phase. In the read phase, each pulse on `rd_trig` issues one read command, and the six payload bytes of the answer are presented on `rd_data` with a one-cycle `rd_valid` strobe.

Top module: `sens_pkt_engine`

## Requirements
- R1: After reset, `tx_valid`, `cfg_done`, `err` and `rd_valid` are 0 and `fail_code` is 0.
- R2: A write command leaves as five bytes: 0xAA, 0x00 (write), register, 0x01 (length), data. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R3: The writes occur in a fixed order, and each one starts only after the previous one succeeds: register 0x07 with data 0x00, then 0x3D with 0x00, then 0x3E with 0x00, then 0x3D with the fusion value (default 0x0C). `cfg_done` rises after the fourth success and then stays high.
- R4: An acknowledge is 0xEE followed by a status byte, and status 0x01 is success. `fail_code` reports the latest outcome: 0 for success, 1 for 0x03, 2 for 0x04, 3 for 0x06, 4 for 0x07, 5 for 0x08, 6 for 0x09, 7 for 0x0A, 8 for any other status or an unexpected reply type, and 9 for a response timeout.
- R5: After a failed reply, the identical command packet is sent again.
- R6: While waiting for a header, any received byte other than 0xEE or 0xBB is dropped, and framing restarts with the next byte.
- R7: In the read phase, `rd_trig` sends 0xAA, 0x01, 0x3D, 0x06. A reply starting with 0xBB is complete at its eighth byte. Two cycles after that byte, `rd_valid` pulses for one cycle, with reply byte 3 in `rd_data[7:0]` up to byte 8 in `rd_data[47:40]`.
- R8: If no complete reply arrives within `TIMEOUT_CYC` cycles after the last command byte, `fail_code` becomes 9 and the command is resent.
- R9: When a reply fails after `MAX_RETRY` resends of the same command, `err` rises and stays high. From then on, `tx_valid` stays 0 and `start` and `rd_trig` have no effect.
- R10: `rd_trig` has no effect before the bring-up sequence has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up sequence (idle only) |
| rd_trig | input | 1 | Periodic read request in read phase |
| tx_data | output | 8 | Command byte to UART core |
| tx_valid | output | 1 | Command byte available |
| tx_ready | input | 1 | UART core accepts byte |
| rx_data | input | 8 | Byte from UART core |
| rx_valid | input | 1 | Received byte strobe |
| cfg_done | output | 1 | Bring-up sequence finished |
| err | output | 1 | Sticky retry-exhausted error |
| fail_code | output | 4 | Decoded outcome of latest reply |
| rd_valid | output | 1 | Read payload strobe |
| rd_data | output | 48 | Six payload bytes of latest read reply |

## Verification
The hardest state to reach from the ports is the sticky error. It needs several consecutive bad replies to one command, and the retry counter is cleared by every success in between. The bench first completes the whole bring-up sequence. It then answers one read command with three failing acknowledges in a row, each with a different status code. Along the way it also lets one command go unanswered so that the shortened timeout window expires and forces a resend.

// File: rtl/sens_pkt_pkg.sv
package sens_pkt_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'hAA;
    localparam logic [7:0] HDR_ACK   = 8'hEE;
    localparam logic [7:0] HDR_READ  = 8'hBB;
    localparam logic [7:0] STAT_OK   = 8'h01;

    localparam logic [7:0] REG_PAGE  = 8'h07;
    localparam logic [7:0] REG_OPMD  = 8'h3D;
    localparam logic [7:0] REG_POWER = 8'h3E;

    localparam logic [3:0] FC_OK      = 4'd0;
    localparam logic [3:0] FC_GENERIC = 4'd8;
    localparam logic [3:0] FC_TIMEOUT = 4'd9;

    typedef enum logic [2:0] {
        STEP_PAGE, STEP_CFGMODE, STEP_POWER, STEP_FUSE, STEP_READ
    } step_e;

    typedef enum logic [2:0] {
        M_IDLE, M_SEND, M_WAIT, M_READY, M_HALT
    } mode_e;

    typedef enum logic [1:0] {K_NONE, K_ACK, K_READ} kind_e;

    function automatic logic [3:0] decode_status(input logic [7:0] s);
        case (s)
            8'h01:   return 4'd0;
            8'h03:   return 4'd1;
            8'h04:   return 4'd2;
            8'h06:   return 4'd3;
            8'h07:   return 4'd4;
            8'h08:   return 4'd5;
            8'h09:   return 4'd6;
            8'h0A:   return 4'd7;
            default: return FC_GENERIC;
        endcase
    endfunction

endpackage

// File: rtl/sens_pkt_tx.sv
module sens_pkt_tx
    import sens_pkt_pkg::*;
#(
    parameter logic [7:0] FUSE_MODE = 8'h0C,
    parameter logic [7:0] RD_REG    = 8'h3D,
    parameter logic [7:0] RD_LEN    = 8'h06
) (
    input  step_e       step,
    input  logic [2:0]  bidx,
    output logic [7:0]  byte_o,
    output logic        last_o
);

    logic       is_rd;
    logic [7:0] reg_a;
    logic [7:0] val;

    always_comb begin
        is_rd = (step == STEP_READ);
        case (step)
            STEP_PAGE:    begin reg_a = REG_PAGE;  val = 8'h00;     end
            STEP_CFGMODE: begin reg_a = REG_OPMD;  val = 8'h00;     end
            STEP_POWER:   begin reg_a = REG_POWER; val = 8'h00;     end
            STEP_FUSE:    begin reg_a = REG_OPMD;  val = FUSE_MODE; end
            default:      begin reg_a = RD_REG;    val = 8'h00;     end
        endcase
        case (bidx)
            3'd0:    byte_o = SYNC_BYTE;
            3'd1:    byte_o = is_rd ? 8'h01 : 8'h00;
            3'd2:    byte_o = reg_a;
            3'd3:    byte_o = is_rd ? RD_LEN : 8'h01;
            default: byte_o = val;
        endcase
        last_o = is_rd ? (bidx == 3'd3) : (bidx == 3'd4);
    end

endmodule

// File: rtl/sens_rsp_framer.sv
module sens_rsp_framer
    import sens_pkt_pkg::*;
#(
    parameter int RD_BYTES = 8,
    localparam int NPAY    = RD_BYTES - 2,
    localparam int IW      = $clog2(RD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              ack_done,
    output logic [7:0]        ack_status,
    output logic              rd_done,
    output logic [NPAY*8-1:0] rd_payload
);

    typedef struct packed {
        kind_e             kind;
        logic [IW-1:0]     idx;
        logic [7:0]        status;
        logic [NPAY*8-1:0] pay;
        logic              ack_done;
        logic              rd_done;
    } fr_t;

    fr_t q, d;

    always_comb begin
        d          = q;
        d.ack_done = 1'b0;
        d.rd_done  = 1'b0;
        if (clr) begin
            d.kind = K_NONE;
            d.idx  = '0;
        end else if (rx_valid) begin
            case (q.kind)
                K_NONE: begin
                    if (rx_data == HDR_ACK) begin
                        d.kind = K_ACK;
                        d.idx  = IW'(1);
                    end else if (rx_data == HDR_READ) begin
                        d.kind = K_READ;
                        d.idx  = IW'(1);
                    end
                end
                K_ACK: begin
                    d.status   = rx_data;
                    d.ack_done = 1'b1;
                    d.kind     = K_NONE;
                    d.idx      = '0;
                end
                default: begin
                    for (int k = 0; k < NPAY; k++) begin
                        if (q.idx == IW'(k + 2)) d.pay[k*8 +: 8] = rx_data;
                    end
                    if (q.idx == IW'(RD_BYTES - 1)) begin
                        d.rd_done = 1'b1;
                        d.kind    = K_NONE;
                        d.idx     = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_done   = q.ack_done;
    assign ack_status = q.status;
    assign rd_done    = q.rd_done;
    assign rd_payload = q.pay;

    // R6: framing idle index never leaves the packet length
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.kind == K_NONE) |-> (q.idx == '0));

endmodule

// File: rtl/sens_pkt_engine.sv
module sens_pkt_engine
    import sens_pkt_pkg::*;
#(
    parameter int          TIMEOUT_CYC = 2000,
    parameter int          MAX_RETRY   = 3,
    parameter logic [7:0]  FUSE_MODE   = 8'h0C,
    parameter logic [7:0]  RD_REG      = 8'h3D,
    parameter int          RD_BYTES    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      rd_trig,
    output logic [7:0]                tx_data,
    output logic                      tx_valid,
    input  logic                      tx_ready,
    input  logic [7:0]                rx_data,
    input  logic                      rx_valid,
    output logic                      cfg_done,
    output logic                      err,
    output logic [3:0]                fail_code,
    output logic                      rd_valid,
    output logic [(RD_BYTES-2)*8-1:0] rd_data
);

    localparam int TW   = $clog2(TIMEOUT_CYC + 1);
    localparam int RW   = $clog2(MAX_RETRY + 1);
    localparam int NPAY = RD_BYTES - 2;

    typedef struct packed {
        mode_e         mode;
        step_e         step;
        logic [2:0]    bidx;
        logic [TW-1:0] tmr;
        logic [RW-1:0] retry;
        logic          done;
        logic          err;
        logic [3:0]    fcode;
        logic          rdv;
    } eng_t;

    eng_t q, d;

    logic       tx_last;
    logic       ack_done, rd_done;
    logic [7:0] ack_status;
    logic       fail;
    logic [3:0] fail_cd;

    sens_pkt_tx #(
        .FUSE_MODE (FUSE_MODE),
        .RD_REG    (RD_REG),
        .RD_LEN    (8'(NPAY))
    ) u_tx (
        .step   (q.step),
        .bidx   (q.bidx),
        .byte_o (tx_data),
        .last_o (tx_last)
    );

    sens_rsp_framer #(.RD_BYTES(RD_BYTES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (q.mode != M_WAIT),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .ack_done   (ack_done),
        .ack_status (ack_status),
        .rd_done    (rd_done),
        .rd_payload (rd_data)
    );

    always_comb begin
        d       = q;
        d.rdv   = 1'b0;
        fail    = 1'b0;
        fail_cd = FC_OK;
        case (q.mode)
            M_IDLE: if (start) begin
                d.mode  = M_SEND;
                d.step  = STEP_PAGE;
                d.bidx  = '0;
                d.retry = '0;
            end
            M_SEND: if (tx_ready) begin
                if (tx_last) begin
                    d.mode = M_WAIT;
                    d.tmr  = '0;
                end else begin
                    d.bidx = q.bidx + 3'd1;
                end
            end
            M_WAIT: begin
                if (q.step == STEP_READ && rd_done) begin
                    d.rdv   = 1'b1;
                    d.fcode = FC_OK;
                    d.retry = '0;
                    d.mode  = M_READY;
                end else if (ack_done && q.step != STEP_READ && ack_status == STAT_OK) begin
                    d.fcode = FC_OK;
                    d.retry = '0;
                    d.bidx  = '0;
                    if (q.step == STEP_FUSE) begin
                        d.step = STEP_READ;
                        d.done = 1'b1;
                        d.mode = M_READY;
                    end else begin
                        d.step = step_e'(q.step + 3'd1);
                        d.mode = M_SEND;
                    end
                end else if (ack_done) begin
                    fail    = 1'b1;
                    fail_cd = decode_status(ack_status);
                    if (fail_cd == FC_OK) fail_cd = FC_GENERIC;
                end else if (rd_done) begin
                    fail    = 1'b1;
                    fail_cd = FC_GENERIC;
                end else if (q.tmr == TW'(TIMEOUT_CYC - 1)) begin
                    fail    = 1'b1;
                    fail_cd = FC_TIMEOUT;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            M_READY: if (rd_trig) begin
                d.mode  = M_SEND;
                d.bidx  = '0;
                d.retry = '0;
            end
            default: ;
        endcase
        if (fail) begin
            d.fcode = fail_cd;
            d.bidx  = '0;
            if (q.retry == RW'(MAX_RETRY)) begin
                d.err  = 1'b1;
                d.mode = M_HALT;
            end else begin
                d.retry = q.retry + 1'b1;
                d.mode  = M_SEND;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.mode  <= M_IDLE;
            q.step  <= STEP_PAGE;
        end else begin
            q <= d;
        end
    end

    assign tx_valid  = (q.mode == M_SEND);
    assign cfg_done  = q.done;
    assign err       = q.err;
    assign fail_code = q.fcode;
    assign rd_valid  = q.rdv;

    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fail_code <= FC_TIMEOUT);

    p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !tx_valid);

    p_trig_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done && !err && !tx_valid && q.mode != M_WAIT) |=> !tx_valid || $past(start));

endmodule

// File: tb/sim_sens_pkt_engine.sv
module sim_sens_pkt_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_trig = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        cfg_done, err, rd_valid;
    logic [3:0]  fail_code;
    logic [47:0] rd_data;

    always #10 clk = ~clk;

    sens_pkt_engine #(.TIMEOUT_CYC(200), .MAX_RETRY(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_trig(rd_trig),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .cfg_done(cfg_done), .err(err), .fail_code(fail_code),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    bit         bp_en = 1'b0;
    bit         fin = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input string tag, input logic [7:0] rw, input logic [7:0] ra,
                            input logic [7:0] len, input logic [7:0] dat, input bit has_data);
        exp_q.push_back(8'hAA); tag_q.push_back(tag);
        exp_q.push_back(rw);    tag_q.push_back(tag);
        exp_q.push_back(ra);    tag_q.push_back(tag);
        exp_q.push_back(len);   tag_q.push_back(tag);
        if (has_data) begin
            exp_q.push_back(dat); tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic ack(input logic [7:0] st);
        rx_byte(8'hEE);
        rx_byte(st);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: ready pattern and scoreboard compare of accepted bytes
    initial begin
        int cyc;
        logic [7:0] e;
        string t;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9/R10 unexpected tx byte", tx_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(tx_data == e, t, tx_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
        chk(cfg_done == 0, "R1 cfg_done", cfg_done, 0);
        chk(err == 0, "R1 err", err, 0);
        chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
        chk(fail_code == 0, "R1 fail_code", fail_code, 0);

        // R10: trigger before bring-up
        rd_trig = 1'b1; @(negedge clk); rd_trig = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tx_valid) seen = 1'b1;
        end
        chk(!seen, "R10 trigger ignored before start", seen, 0);

        // page select with backpressure (R2, R3)
        bp_en = 1'b1;
        push_cmd("R2 page write bytes", 8'h00, 8'h07, 8'h01, 8'h00, 1'b1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        drain();
        bp_en = 1'b0;
        // R6: junk before header
        push_cmd("R3 config-mode write bytes", 8'h00, 8'h3D, 8'h01, 8'h00, 1'b1);
        rx_byte(8'h55);
        ack(8'h01);
        chk(fail_code == 0, "R6 success after junk byte", fail_code, 0);
        drain();

        // R4/R5: failed ack then resend
        push_cmd("R5 resend config-mode", 8'h00, 8'h3D, 8'h01, 8'h00, 1'b1);
        ack(8'h03);
        chk(fail_code == 1, "R4 status 0x03", fail_code, 1);
        drain();
        push_cmd("R3 power write bytes", 8'h00, 8'h3E, 8'h01, 8'h00, 1'b1);
        ack(8'h01);
        drain();
        push_cmd("R5 resend power", 8'h00, 8'h3E, 8'h01, 8'h00, 1'b1);
        ack(8'h2A);
        chk(fail_code == 8, "R4 unknown status", fail_code, 8);
        drain();
        push_cmd("R3 fusion write bytes", 8'h00, 8'h3D, 8'h01, 8'h0C, 1'b1);
        ack(8'h01);
        drain();

        // R8: timeout
        push_cmd("R8 resend after timeout", 8'h00, 8'h3D, 8'h01, 8'h0C, 1'b1);
        drain();
        chk(fail_code == 9, "R8 timeout code", fail_code, 9);
        chk(cfg_done == 0, "R3 not done before final ack", cfg_done, 0);
        ack(8'h01);
        chk(cfg_done == 1, "R3 done after fourth success", cfg_done, 1);
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tx_valid) seen = 1'b1;
        end
        chk(!seen, "R7 no command without trigger", seen, 0);

        // R7: read cycle with leading junk
        push_cmd("R7 read command bytes", 8'h01, 8'h3D, 8'h06, 8'h00, 1'b0);
        rd_trig = 1'b1; @(negedge clk); rd_trig = 1'b0;
        drain();
        rx_byte(8'h13);
        rx_byte(8'hBB);
        rx_byte(8'h06);
        for (int i = 0; i < 6; i++) rx_byte(8'h11 + 8'(i));
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (!seen && rd_valid) begin
                seen = 1'b1;
                chk(rd_data == 48'h161514131211, "R7 read payload", rd_data, 48'h161514131211);
            end
            @(negedge clk);
        end
        chk(seen, "R7 rd_valid strobe", seen, 1);

        // R9: three failing acks on one read command
        push_cmd("R5 read resend 1", 8'h01, 8'h3D, 8'h06, 8'h00, 1'b0);
        push_cmd("R7 read command bytes", 8'h01, 8'h3D, 8'h06, 8'h00, 1'b0);
        rd_trig = 1'b1; @(negedge clk); rd_trig = 1'b0;
        while (exp_q.size() > 4) @(negedge clk);
        repeat (2) @(negedge clk);
        ack(8'h07);
        chk(fail_code == 4, "R4 status 0x07", fail_code, 4);
        drain();
        push_cmd("R5 read resend 2", 8'h01, 8'h3D, 8'h06, 8'h00, 1'b0);
        ack(8'h0A);
        chk(fail_code == 7, "R4 status 0x0A", fail_code, 7);
        drain();
        ack(8'h09);
        chk(fail_code == 6, "R4 status 0x09", fail_code, 6);
        chk(err == 1, "R9 err after retries", err, 1);
        seen = 1'b0;
        start = 1'b1; rd_trig = 1'b1; @(negedge clk); start = 1'b0; rd_trig = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_valid) seen = 1'b1;
        end
        chk(!seen, "R9 quiet after error", seen, 0);
        chk(err == 1, "R9 err sticky", err, 1);

        fin = 1'b1;
        summary();
        $finish;
    end

endmodule